// File: doc/BRIEF.md
# Paged Data Memory Address Unit

An 8-bit processor core can only put 8-bit data addresses on its bus. That limits each access to a window of 256 bytes. This unit widens those addresses into a larger data space. It adds a page number in front of the 8-bit offset. The page number comes from one of five small page registers, chosen by the kind of access the core is making:

- plain direct access
- indexed access through a pointer
- stack push or pop
- the read side of a block move
- the write side of a block move

A 2-bit paging mode from the core's flag register decides which register serves the direct, indexed and stack accesses. When an interrupt is being serviced, every access is forced to page 0. The same happens in the flat (no-paging) mode.

The core writes the page registers through a small register-file port and reads them back through a second port. For block moves, the unit also gives the address that follows the current one. Only the offset advances, and it wraps inside the same page, so a move pointer never leaves its page. Both address outputs and the read-back value are registered. They appear one clock after the inputs that produce them.

Top module: `paged_addr_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `addr_o`, `next_addr_o` and `rd_data` are 0, and every page register holds 0.
- R2: A write with `wr_en` high stores `wr_data` into the register named by `wr_sel`. The codes are 0 current page, 1 stack page, 2 indexed page, 3 move-read page, 4 move-write page. `rd_data` shows the register named by `rd_sel` one clock after `rd_sel` is presented.
- R3: Select codes 5, 6 and 7 name no register. A write with such a select changes no page register, and a read with such a select returns 0.
- R4: One clock after an access is presented, `addr_o` equals {page, offset}, with the page in bits 10:8 and the offset in bits 7:0. Access codes are 0 direct, 1 indexed, 2 stack, 3 move-read and 4 move-write. Codes 5 to 7 resolve to page 0.
- R5: In paging mode 0 (flat), every access type resolves to page 0.
- R6: While `irq_active` is high, every access resolves to page 0 in every paging mode.
- R7: In paging mode 1, direct accesses use page 0. Indexed and stack accesses use the stack page.
- R8: In paging mode 2, direct accesses use the current page and indexed accesses use the indexed page.
- R9: In paging mode 3, direct accesses use the current page and indexed accesses use the stack page.
- R10: In paging modes 1 to 3, with no interrupt active, stack accesses always use the stack page. Move-read uses the move-read page and move-write uses the move-write page.
- R11: `next_addr_o` carries the same page as `addr_o`, with the offset plus one modulo 256. An offset of 0xFF wraps to 0x00 and stays in the same page.
- R12: A page register written on one clock edge is used by an access presented in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Page register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 3 | Page number to write |
| rd_sel | input | 3 | Register select for read-back |
| rd_data | output | 3 | Registered read-back value |
| acc_type | input | 3 | Access kind of the current core access |
| offset | input | 8 | 8-bit address issued by the core |
| mode | input | 2 | Paging mode from the flag register |
| irq_active | input | 1 | Interrupt service in progress |
| addr_o | output | 11 | Registered full data address |
| next_addr_o | output | 11 | Registered post-increment address within the page |

## Verification
The five page registers are loaded with five distinct non-zero pages. Because of this, every resolved address points to exactly one source register. A wrong choice between the current, stack and indexed registers shows up as a wrong page number.

A table of hand-picked accesses is applied first. It is followed by a sweep over all modes, interrupt states and access kinds. The sweep separates:
- the flat mode from the paged modes;
- the interrupt override from the mode decode;
- modes 2 and 3, which differ only on indexed accesses.

Directed cases cover:
- offset 0xFF, to show in-page wrap;
- writes through unused selects;
- a write immediately followed by an access;
- a reset that clears loaded registers.

// File: rtl/pam_pkg.sv
package pam_pkg;

  typedef enum logic [1:0] {
    PM_FLAT   = 2'd0,
    PM_STKIDX = 2'd1,
    PM_CURIDX = 2'd2,
    PM_CURSTK = 2'd3
  } pmode_e;

  typedef enum logic [2:0] {
    AC_DIRECT = 3'd0,
    AC_INDEX  = 3'd1,
    AC_STACK  = 3'd2,
    AC_MVRD   = 3'd3,
    AC_MVWR   = 3'd4
  } acc_e;

  localparam int REG_CUR  = 0;
  localparam int REG_STK  = 1;
  localparam int REG_IDX  = 2;
  localparam int REG_MVRD = 3;
  localparam int REG_MVWR = 4;
  localparam int NUM_PREGS = 5;

endpackage

// File: rtl/pam_page_regs.sv
module pam_page_regs #(
  parameter int PAGE_W   = 3,
  parameter int NUM_REGS = 5,
  parameter int SEL_W    = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [SEL_W-1:0]           wr_sel,
  input  logic [PAGE_W-1:0]          wr_data,
  input  logic [SEL_W-1:0]           rd_sel,
  output logic [PAGE_W-1:0]          rd_data,
  output logic [NUM_REGS*PAGE_W-1:0] pages
);

  logic [PAGE_W-1:0] pg_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_preg
    always_ff @(posedge clk) begin
      if (rst) begin
        pg_q[i] <= '0;
      end else if (wr_en && (int'(wr_sel) == i)) begin
        pg_q[i] <= wr_data;
      end
    end
    assign pages[i*PAGE_W +: PAGE_W] = pg_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (int'(rd_sel) < NUM_REGS) begin
      rd_data <= pages[int'(rd_sel)*PAGE_W +: PAGE_W];
    end else begin
      rd_data <= '0;
    end
  end

endmodule

// File: rtl/pam_page_sel.sv
module pam_page_sel
  import pam_pkg::*;
#(
  parameter int PAGE_W   = 3,
  parameter int NUM_REGS = 5
) (
  input  logic [NUM_REGS*PAGE_W-1:0] pages,
  input  logic [2:0]                 acc_type,
  input  logic [1:0]                 mode,
  input  logic                       irq_active,
  output logic [PAGE_W-1:0]          page
);

  logic [PAGE_W-1:0] cur_pg, stk_pg, idx_pg, mvr_pg, mvw_pg;
  pmode_e pm;
  acc_e   ac;

  assign cur_pg = pages[REG_CUR*PAGE_W  +: PAGE_W];
  assign stk_pg = pages[REG_STK*PAGE_W  +: PAGE_W];
  assign idx_pg = pages[REG_IDX*PAGE_W  +: PAGE_W];
  assign mvr_pg = pages[REG_MVRD*PAGE_W +: PAGE_W];
  assign mvw_pg = pages[REG_MVWR*PAGE_W +: PAGE_W];
  assign pm     = pmode_e'(mode);
  assign ac     = acc_e'(acc_type);

  always_comb begin
    page = '0;
    if (!irq_active && (pm != PM_FLAT)) begin
      case (ac)
        AC_DIRECT: page = (pm == PM_STKIDX) ? '0 : cur_pg;
        AC_INDEX:  page = (pm == PM_CURIDX) ? idx_pg : stk_pg;
        AC_STACK:  page = stk_pg;
        AC_MVRD:   page = mvr_pg;
        AC_MVWR:   page = mvw_pg;
        default:   page = '0;
      endcase
    end
  end

endmodule

// File: rtl/paged_addr_unit.sv
module paged_addr_unit
  import pam_pkg::*;
#(
  parameter int PAGE_W = 3,
  parameter int OFS_W  = 8,
  parameter int SEL_W  = 3,
  localparam int ADDR_W = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [PAGE_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [PAGE_W-1:0] rd_data,
  input  logic [2:0]        acc_type,
  input  logic [OFS_W-1:0]  offset,
  input  logic [1:0]        mode,
  input  logic              irq_active,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] next_addr_o
);

  logic [NUM_PREGS*PAGE_W-1:0] pages;
  logic [PAGE_W-1:0]           sel_page;
  logic [OFS_W-1:0]            ofs_inc;

  pam_page_regs #(
    .PAGE_W  (PAGE_W),
    .NUM_REGS(NUM_PREGS),
    .SEL_W   (SEL_W)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_data(wr_data),
    .rd_sel (rd_sel),
    .rd_data(rd_data),
    .pages  (pages)
  );

  pam_page_sel #(
    .PAGE_W  (PAGE_W),
    .NUM_REGS(NUM_PREGS)
  ) u_sel (
    .pages     (pages),
    .acc_type  (acc_type),
    .mode      (mode),
    .irq_active(irq_active),
    .page      (sel_page)
  );

  // Post-increment stays within the page: only the offset field advances.
  assign ofs_inc = offset + OFS_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o      <= '0;
      next_addr_o <= '0;
    end else begin
      addr_o      <= {sel_page, offset};
      next_addr_o <= {sel_page, ofs_inc};
    end
  end

endmodule

// File: rtl/pam_chk.sv
module pam_chk #(
  parameter int PAGE_W = 3,
  parameter int OFS_W  = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic [1:0]              mode,
  input logic                    irq_active,
  input logic [OFS_W-1:0]        offset,
  input logic [PAGE_W+OFS_W-1:0] addr_o,
  input logic [PAGE_W+OFS_W-1:0] next_addr_o
);

  // R6
  irq_page_zero_chk: assert property (@(posedge clk) disable iff (rst)
    irq_active |=> (addr_o[PAGE_W+OFS_W-1:OFS_W] == '0));

  // R5
  flat_page_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0) |=> (addr_o[PAGE_W+OFS_W-1:OFS_W] == '0));

  // R4
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (addr_o[OFS_W-1:0] == $past(offset)));

  // R11
  next_ofs_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (next_addr_o[OFS_W-1:0] == OFS_W'($past(offset) + 1'b1)));

  // R11
  next_same_page_chk: assert property (@(posedge clk) disable iff (rst)
    next_addr_o[PAGE_W+OFS_W-1:OFS_W] == addr_o[PAGE_W+OFS_W-1:OFS_W]);

endmodule

bind paged_addr_unit pam_chk #(
  .PAGE_W(PAGE_W),
  .OFS_W (OFS_W)
) u_pam_chk (
  .clk        (clk),
  .rst        (rst),
  .mode       (mode),
  .irq_active (irq_active),
  .offset     (offset),
  .addr_o     (addr_o),
  .next_addr_o(next_addr_o)
);

// File: tb/test_paged_addr_unit.sv
module test_paged_addr_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [2:0]  wr_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [2:0]  rd_data;
  logic [2:0]  acc_type = '0;
  logic [7:0]  offset = '0;
  logic [1:0]  mode = '0;
  logic        irq_active = 1'b0;
  logic [10:0] addr_o;
  logic [10:0] next_addr_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #10 clk = ~clk;

  paged_addr_unit i_paged_addr_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .acc_type(acc_type), .offset(offset),
    .mode(mode), .irq_active(irq_active), .addr_o(addr_o), .next_addr_o(next_addr_o)
  );

  // Loaded pages: current 1, stack 2, indexed 3, move-read 4, move-write 5.
  // Entry: {mode, irq, acc_type, offset, expected page}
  localparam int NV = 18;
  localparam logic [16:0] VEC [NV] = '{
    {2'd0, 1'b0, 3'd0, 8'h10, 3'd0},   // R5
    {2'd0, 1'b0, 3'd2, 8'h11, 3'd0},   // R5
    {2'd0, 1'b0, 3'd3, 8'h12, 3'd0},   // R5
    {2'd1, 1'b0, 3'd0, 8'h20, 3'd0},   // R7
    {2'd1, 1'b0, 3'd1, 8'h21, 3'd2},   // R7
    {2'd1, 1'b0, 3'd2, 8'h22, 3'd2},   // R7
    {2'd1, 1'b0, 3'd3, 8'h23, 3'd4},   // R10
    {2'd1, 1'b0, 3'd4, 8'h24, 3'd5},   // R10
    {2'd2, 1'b0, 3'd0, 8'h30, 3'd1},   // R8
    {2'd2, 1'b0, 3'd1, 8'h31, 3'd3},   // R8
    {2'd2, 1'b0, 3'd2, 8'h32, 3'd2},   // R10
    {2'd3, 1'b0, 3'd0, 8'h40, 3'd1},   // R9
    {2'd3, 1'b0, 3'd1, 8'h41, 3'd2},   // R9
    {2'd3, 1'b0, 3'd4, 8'h42, 3'd5},   // R10
    {2'd3, 1'b1, 3'd0, 8'h50, 3'd0},   // R6
    {2'd2, 1'b1, 3'd1, 8'h51, 3'd0},   // R6
    {2'd1, 1'b1, 3'd3, 8'h52, 3'd0},   // R6
    {2'd2, 1'b0, 3'd6, 8'h60, 3'd0}    // R4
  };

  function automatic logic [2:0] ref_page(input logic [1:0] m, input logic irq,
                                          input logic [2:0] t);
    if (irq || m == 2'd0) return 3'd0;
    case (t)
      3'd0: return (m == 2'd1) ? 3'd0 : 3'd1;
      3'd1: return (m == 2'd2) ? 3'd3 : 3'd2;
      3'd2: return 3'd2;
      3'd3: return 3'd4;
      3'd4: return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_page(input logic [2:0] s, input logic [2:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [2:0] s, input logic [2:0] exp);
    @(negedge clk);
    rd_sel = s;
    @(negedge clk);
    check(req, {8'h0, rd_data}, {8'h0, exp});
  endtask

  task automatic access(input string req, input logic [1:0] m, input logic irq,
                        input logic [2:0] t, input logic [7:0] o, input logic [2:0] pg);
    @(negedge clk);
    mode = m; irq_active = irq; acc_type = t; offset = o;
    @(negedge clk);
    check(req, addr_o, {pg, o});
    check({req, "/R11"}, next_addr_o, {pg, o + 8'd1});
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
      finish_run();
    end
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    check("R1 addr", addr_o, 11'h0);
    check("R1 next", next_addr_o, 11'h0);
    check("R1 rd", {8'h0, rd_data}, 11'h0);
    rst = 1'b0;
    rd_check("R1 reg", 3'd1, 3'd0);

    // R2 load and read back
    for (int i = 0; i < 5; i++) wr_page(3'(i), 3'(i + 1));
    for (int i = 0; i < 5; i++) rd_check("R2", 3'(i), 3'(i + 1));

    // R3 unused selects
    wr_page(3'd5, 3'd7);
    wr_page(3'd6, 3'd7);
    wr_page(3'd7, 3'd7);
    for (int i = 0; i < 5; i++) rd_check("R3 unchanged", 3'(i), 3'(i + 1));
    rd_check("R3 read", 3'd6, 3'd0);
    access("R3 access", 2'd2, 1'b0, 3'd0, 8'h77, 3'd1);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      access("R4 vec", VEC[v][16:15], VEC[v][14], VEC[v][13:11], VEC[v][10:3], VEC[v][2:0]);
    end

    // Full sweep R5 R6 R7 R8 R9 R10
    for (int m = 0; m < 4; m++)
      for (int q = 0; q < 2; q++)
        for (int t = 0; t < 5; t++)
          access("R5-sweep", 2'(m), 1'(q), 3'(t), 8'(m * 40 + q * 10 + t),
                 ref_page(2'(m), 1'(q), 3'(t)));

    // R11 wrap at end of page
    access("R11 wrap", 2'd3, 1'b0, 3'd3, 8'hFF, 3'd4);
    access("R11 wrap0", 2'd1, 1'b0, 3'd4, 8'hFF, 3'd5);

    // R12 write then immediate use
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd1; wr_data = 3'd6;
    mode = 2'd1; irq_active = 1'b0; acc_type = 3'd2; offset = 8'h33;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    check("R12", addr_o, {3'd6, 8'h33});

    // R1 reset clears loaded registers
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd_check("R1 cleared", 3'd1, 3'd0);
    access("R1 cleared page", 2'd2, 1'b0, 3'd0, 8'h05, 3'd0);

    finish_run();
  end

endmodule